// File: doc/BRIEF.md
# Keyboard Scan Code Event Decoder

This block sits after a PS/2 keyboard receiver whose lines have already been brought into the system clock domain and whose bits have already been assembled into bytes. It takes one byte per cycle, qualified by a valid strobe, and turns that byte stream into discrete key events. One key action can span several bytes. A release marker byte (0xF0) or an extended marker byte (0xE0) comes before the key code. The decoder keeps these markers pending until the next key code arrives. It then emits a single tagged event that carries the key code, a release bit and an extended bit.

Alongside the full event stream, a forward strobe selects only the event kinds a downstream consumer wants. A typical consumer is a memory writer that records key presses. A two-bit mask input picks the kinds, so the writer needs no decoding logic of its own. All outputs are registered. Reset is synchronous and active high.

Top module: `kbd_scan_event`

## Requirements
- R1: While `rst` is high, no event or forward strobe is produced. Reset discards any pending release or extended marker, so a key code byte after reset reports a plain press.
- R2: A valid byte other than 0xF0 or 0xE0, arriving with no marker pending, produces an event in the cycle after it is accepted. The event has `evt_code` equal to the byte, `evt_rel`=0 and `evt_ext`=0.
- R3: The byte 0xF0 produces no event and marks a pending release. The next key code byte produces one event with `evt_rel`=1 and that byte as its code.
- R4: The byte 0xE0 produces no event and marks a pending extended flag. The next key code byte produces one event with `evt_ext`=1.
- R5: The orders 0xE0, 0xF0, code and 0xF0, 0xE0, code both produce a single event with `evt_rel`=1 and `evt_ext`=1.
- R6: An event consumes all pending markers. The key code byte that follows it reports a plain press.
- R7: `evt_vld` is high for exactly one cycle per key code byte. Cycles with `byte_vld` low change nothing, whatever value `byte_data` carries, and pending markers survive such idle cycles.
- R8: `fwd_vld` pulses together with `evt_vld` only when the mask bit for that event kind is set. Bit 0 of `fwd_mask` forwards presses and bit 1 forwards releases. The mask is sampled in the same cycle as the key code byte.
- R9: A make code that repeats for a held key produces one press event per byte. Back-to-back repeats are not filtered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_vld | input | 1 | Marks `byte_data` as a received byte this cycle |
| byte_data | input | 8 | Received keyboard byte |
| fwd_mask | input | 2 | Kinds to forward: bit 0 press, bit 1 release |
| evt_vld | output | 1 | One-cycle key event pulse |
| evt_code | output | 8 | Key code of the event |
| evt_rel | output | 1 | Event is a release |
| evt_ext | output | 1 | Event came after an extended marker |
| fwd_vld | output | 1 | Event pulse gated by the mask |

## Verification
The first sequence is a lone key code. It is followed by a release pair, with and without idle cycles between the marker and the code, and this shows whether marker state survives gaps. Extended sequences in both marker orders check that the two flags are independent and that both are consumed together. Back-to-back repeats show that no auto-repeat filtering takes place. A reset that falls between a marker and its code shows whether reset discards context. A sweep over all four mask values with presses and releases separates the two forward enables.

// File: rtl/kbd_evt_pkg.sv
package kbd_evt_pkg;

  localparam int CODE_W = 8;
  localparam int KIND_N = 2;           // press, release

  typedef enum logic [1:0] {
    BC_KEY = 2'd0,
    BC_REL = 2'd1,
    BC_EXT = 2'd2
  } byte_cls_e;

  typedef struct packed {
    logic [CODE_W-1:0] code;
    logic              rel;
    logic              ext;
  } key_evt_t;

endpackage

// File: rtl/kbd_byte_class.sv
module kbd_byte_class
  import kbd_evt_pkg::*;
#(
  parameter int                W          = CODE_W,
  parameter logic [CODE_W-1:0] REL_MARKER = 8'hF0,
  parameter logic [CODE_W-1:0] EXT_MARKER = 8'hE0
) (
  input  logic [W-1:0] byte_i,
  output byte_cls_e    cls_o
);

  always_comb begin
    if (byte_i == REL_MARKER[W-1:0])      cls_o = BC_REL;
    else if (byte_i == EXT_MARKER[W-1:0]) cls_o = BC_EXT;
    else                                  cls_o = BC_KEY;
  end

endmodule

// File: rtl/kbd_prefix_track.sv
module kbd_prefix_track
  import kbd_evt_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      take_i,
  input  byte_cls_e cls_i,
  output logic      key_fire_o,
  output logic      rel_pend_o,
  output logic      ext_pend_o
);

  logic rel_q, ext_q;

  assign key_fire_o = take_i && (cls_i == BC_KEY);
  assign rel_pend_o = rel_q;
  assign ext_pend_o = ext_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rel_q <= 1'b0;
      ext_q <= 1'b0;
    end else if (take_i) begin
      unique case (cls_i)
        BC_REL:  rel_q <= 1'b1;
        BC_EXT:  ext_q <= 1'b1;
        default: begin
          rel_q <= 1'b0;
          ext_q <= 1'b0;
        end
      endcase
    end
  end

  AST_MARKERS_CONSUMED: assert property (@(posedge clk) disable iff (rst)
    key_fire_o |=> (!rel_q && !ext_q)); // R6

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!take_i && !$past(rst)) |=> ($stable(rel_q) && $stable(ext_q))); // R7

endmodule

// File: rtl/kbd_evt_out.sv
module kbd_evt_out
  import kbd_evt_pkg::*;
#(
  parameter int KINDS = KIND_N
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire_i,
  input  key_evt_t         evt_i,
  input  logic [KINDS-1:0] mask_i,
  output logic             vld_o,
  output key_evt_t         evt_o,
  output logic             fwd_o
);

  logic [KINDS-1:0] kind_hit;

  // one enable per event kind: index 0 press, index 1 release
  for (genvar k = 0; k < KINDS; k++) begin : g_kind
    always_comb kind_hit[k] = mask_i[k] && (evt_i.rel == k[0]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o <= 1'b0;
      fwd_o <= 1'b0;
      evt_o <= '0;
    end else begin
      vld_o <= fire_i;
      fwd_o <= fire_i && (|kind_hit);
      if (fire_i) evt_o <= evt_i;
    end
  end

  AST_FWD_SUBSET: assert property (@(posedge clk) disable iff (rst)
    fwd_o |-> vld_o); // R8

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    !fire_i |=> !vld_o); // R7

endmodule

// File: rtl/kbd_scan_event.sv
module kbd_scan_event
  import kbd_evt_pkg::*;
#(
  parameter logic [CODE_W-1:0] REL_MARKER = 8'hF0,
  parameter logic [CODE_W-1:0] EXT_MARKER = 8'hE0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_vld,
  input  logic [CODE_W-1:0] byte_data,
  input  logic [KIND_N-1:0] fwd_mask,
  output logic              evt_vld,
  output logic [CODE_W-1:0] evt_code,
  output logic              evt_rel,
  output logic              evt_ext,
  output logic              fwd_vld
);

  byte_cls_e cls;
  logic      fire, rel_pend, ext_pend;
  key_evt_t  evt_next, evt_q;

  kbd_byte_class #(
    .W(CODE_W), .REL_MARKER(REL_MARKER), .EXT_MARKER(EXT_MARKER)
  ) u_class (
    .byte_i(byte_data),
    .cls_o (cls)
  );

  kbd_prefix_track u_track (
    .clk       (clk),
    .rst       (rst),
    .take_i    (byte_vld),
    .cls_i     (cls),
    .key_fire_o(fire),
    .rel_pend_o(rel_pend),
    .ext_pend_o(ext_pend)
  );

  always_comb begin
    evt_next.code = byte_data;
    evt_next.rel  = rel_pend;
    evt_next.ext  = ext_pend;
  end

  kbd_evt_out #(.KINDS(KIND_N)) u_out (
    .clk   (clk),
    .rst   (rst),
    .fire_i(fire),
    .evt_i (evt_next),
    .mask_i(fwd_mask),
    .vld_o (evt_vld),
    .evt_o (evt_q),
    .fwd_o (fwd_vld)
  );

  assign evt_code = evt_q.code;
  assign evt_rel  = evt_q.rel;
  assign evt_ext  = evt_q.ext;

  AST_REL_SILENT: assert property (@(posedge clk) disable iff (rst)
    (byte_vld && byte_data == REL_MARKER) |=> !evt_vld); // R3

  AST_EXT_SILENT: assert property (@(posedge clk) disable iff (rst)
    (byte_vld && byte_data == EXT_MARKER) |=> !evt_vld); // R4

  AST_CODE_ECHO: assert property (@(posedge clk) disable iff (rst)
    evt_vld |-> (evt_code == $past(byte_data) && $past(byte_vld))); // R2

endmodule

// File: tb/kbd_scan_event_tb.sv
module kbd_scan_event_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       byte_vld = 1'b0;
  logic [7:0] byte_data = 8'h00;
  logic [1:0] fwd_mask = 2'b11;
  logic       evt_vld, evt_rel, evt_ext, fwd_vld;
  logic [7:0] evt_code;

  int    n_checks = 0;
  int    n_fail = 0;
  string cur_req = "R1";
  bit    live = 0;
  bit    done = 0;

  // reference model state
  bit       m_rel = 0, m_ext = 0;
  bit       x_vld = 0, x_rel = 0, x_ext = 0, x_fwd = 0;
  int       x_code = 0;

  always #10 clk = ~clk;

  kbd_scan_event u_dut (
    .clk(clk), .rst(rst), .byte_vld(byte_vld), .byte_data(byte_data),
    .fwd_mask(fwd_mask), .evt_vld(evt_vld), .evt_code(evt_code),
    .evt_rel(evt_rel), .evt_ext(evt_ext), .fwd_vld(fwd_vld)
  );

  always @(posedge clk) begin
    live = 1;
    if (rst) begin
      m_rel = 0; m_ext = 0; x_vld = 0; x_fwd = 0;
    end else begin
      x_vld = 0; x_fwd = 0;
      if (byte_vld) begin
        if (byte_data == 8'hF0) m_rel = 1;
        else if (byte_data == 8'hE0) m_ext = 1;
        else begin
          x_vld = 1; x_code = int'(byte_data); x_rel = m_rel; x_ext = m_ext;
          x_fwd = m_rel ? fwd_mask[1] : fwd_mask[0];
          m_rel = 0; m_ext = 0;
        end
      end
    end
  end

  task automatic chk(string what, int got, int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s got %0h exp %0h", cur_req, what, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (live && !done) begin
      chk("evt_vld", int'(evt_vld), int'(x_vld));
      chk("fwd_vld", int'(fwd_vld), int'(x_fwd));
      if (x_vld) begin
        chk("evt_code", int'(evt_code), x_code);
        chk("evt_rel", int'(evt_rel), int'(x_rel));
        chk("evt_ext", int'(evt_ext), int'(x_ext));
      end
    end
  end

  task automatic send(input logic [7:0] b, input logic [1:0] m = 2'b11);
    @(negedge clk); #1;
    byte_vld = 1'b1; byte_data = b; fwd_mask = m;
  endtask

  task automatic idle(input int n, input logic [7:0] junk = 8'h00);
    @(negedge clk); #1;
    byte_vld = 1'b0; byte_data = junk;
    for (int i = 1; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(20 * 20000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired in %s", cur_req);
    finish_run();
  end

  initial begin
    // R1: quiet during reset, even with bytes offered
    cur_req = "R1";
    send(8'h1C);
    idle(3);
    @(negedge clk);
    chk("evt_vld in reset", int'(evt_vld), 0);
    chk("fwd_vld in reset", int'(fwd_vld), 0);
    #1 rst = 1'b0;
    idle(2);

    cur_req = "R2"; send(8'h1C); idle(2);
    cur_req = "R3"; send(8'hF0); send(8'h1C); idle(2);
    cur_req = "R7"; send(8'hF0); idle(3, 8'hE0); send(8'h1C); idle(1);
    idle(2, 8'h2A);
    cur_req = "R4"; send(8'hE0); send(8'h75); idle(2);
    cur_req = "R5"; send(8'hE0); send(8'hF0); send(8'h75); idle(1);
    send(8'hF0); send(8'hE0); send(8'h6B); idle(2);
    cur_req = "R6"; send(8'hF0); send(8'h1C); send(8'h1C);
    send(8'hE0); send(8'h74); send(8'h74); idle(2);
    cur_req = "R9"; send(8'h1C); send(8'h1C); send(8'h1C); idle(1);
    cur_req = "R8";
    for (int m = 0; m < 4; m++) begin
      send(8'h23, 2'(m)); idle(1);
      send(8'hF0, 2'(m)); send(8'h23, 2'(m)); idle(1);
    end
    send(8'hF0, 2'b00); send(8'h23, 2'b10); idle(2);
    // R1: reset between a marker and its code discards the marker
    cur_req = "R1";
    send(8'hF0); send(8'hE0); idle(1);
    @(negedge clk); #1 rst = 1'b1;
    @(negedge clk); @(negedge clk); #1 rst = 1'b0;
    send(8'h1C); idle(3);
    finish_run();
  end

endmodule